// File: doc/BRIEF.md
# IOMMU Event Log Writer

This block is the producer side of a circular fault log kept in system memory. Five requesters from the translation and command logic report errors: command fetch hardware error, device-table hardware error, page-table hardware error, invalid device request and I/O page fault. The block accepts one event at a time, packs it into a 128-bit record, writes the record to memory at the tail slot of the ring and sets a level interrupt flag. Software programs the ring base address, its size (a power of two) and an enable. It consumes records by moving the head index forward.

When the ring has no free slot, a new event is accepted and thrown away, and a sticky overflow flag records the loss. Records already written are never overwritten. While logging is disabled, events are accepted and discarded without touching the overflow flag. Requesters use a request/acknowledge handshake. A requester keeps its request and payload until it sees its acknowledge at a clock edge, so requesters that lose arbitration, or that arrive while a record is being written, simply wait.

The control is a two-state machine. In IDLE the arbiter may grant. The transition IDLE to WRITE ("accept-store") is taken when a granted event finds logging enabled and a free slot. The self-loop IDLE to IDLE ("accept-drop") is taken when logging is disabled or the ring is full. In WRITE the record is offered to memory. The self-loop WRITE to WRITE ("stall") holds while memory is not ready. The transition WRITE to IDLE ("commit") is taken on the memory handshake; it advances the tail and raises the interrupt.

Top module: `evlog_writer`

## Requirements
- R1: A record is 128 bits. It holds the device ID in bits 15:0, the read flag (src_rw bit 0) in bit 16, the write flag (src_rw bit 1) in bit 17, zeros in bits 59:18, the event code in bits 63:60 and the 64-bit address in bits 127:64.
- R2: Source index picks the event type and its code: 0 command hardware error = 4'h6, 1 device-table hardware error = 4'h3, 2 page-table hardware error = 4'h4, 3 invalid device request = 4'h1, 4 I/O page fault = 4'h2. Among simultaneous requests the lowest index is granted, and at most one acknowledge is high in any cycle.
- R3: The ring holds at most 2^log_size − 1 records. If ((tail+1) mod 2^log_size) equals the head when an event is accepted, the event produces no memory write and ovf_flag is set.
- R4: ovf_flag stays set until a cycle with ovf_clr high. If a drop and a clear fall in the same cycle, the flag stays set.
- R5: Every committed record sets irq_flag. A cycle with irq_clr high clears it, unless a record commits in the same cycle.
- R6: With log_en low, an accepted event causes no memory write, leaves log_tail unchanged and does not set ovf_flag.
- R7: A record is written at log_base + 16·log_tail. After each commit, log_tail becomes (log_tail+1) mod 2^log_size.
- R8: Once mem_wr_valid is high, it stays high with unchanged address and data until the cycle in which mem_wr_ready is high.
- R9: While a record is pending (mem_wr_valid high), every src_ack is low, and requesters stay held.
- R10: In IDLE, src_ack rises in the same cycle as the winning request. For a stored event, mem_wr_valid is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| log_en | input | 1 | Logging enable |
| log_base | input | AW | Ring base byte address |
| log_size | input | SZ_W | Log2 of ring slot count (clamped to IDX_W) |
| log_head | input | IDX_W | Software read index |
| ovf_clr | input | 1 | Clear overflow flag (write-1 pulse) |
| irq_clr | input | 1 | Clear interrupt flag (write-1 pulse) |
| src_req | input | 5 | Event requests, index = source |
| src_dev | input | 5·16 | Device ID per source |
| src_addr | input | 5·64 | Address per source |
| src_rw | input | 5·2 | Read/write flags per source |
| src_ack | output | 5 | Acknowledge, event taken at this edge |
| mem_wr_valid | output | 1 | Record write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Record byte address |
| mem_wr_data | output | 128 | Record contents |
| log_tail | output | IDX_W | Current write index |
| ovf_flag | output | 1 | Sticky overflow status |
| irq_flag | output | 1 | Level interrupt |

## Verification
src_ack is combinational in IDLE, so the bench samples it 1 ns after driving a request, well before the next rising edge. mem_wr_valid is due at the falling edge that follows the accepting rising edge. log_tail and irq_flag are due one rising edge after the falling edge at which the bench saw valid and ready both high. ovf_flag is due one edge after the accept. The bench drives mem_wr_ready at falling edges and checks each record at the falling edge before the handshake edge. Flags and the tail index are compared only after the machine has returned to IDLE, against a reference model of head, tail and flags that the bench keeps.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
    localparam int NSRC        = 5;
    localparam int ENTRY_W     = 128;
    localparam int ENTRY_SHIFT = 4;   // 16 bytes per record

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } wr_state_t;

    typedef struct packed {
        logic [63:0] addr;
        logic [3:0]  code;
        logic [41:0] rsvd;
        logic [1:0]  rw;
        logic [15:0] dev;
    } entry_t;

    // source index -> event code, index order is also the priority order
    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            0:       return 4'h6;  // command hardware error
            1:       return 4'h3;  // device-table hardware error
            2:       return 4'h4;  // page-table hardware error
            3:       return 4'h1;  // invalid device request
            default: return 4'h2;  // I/O page fault
        endcase
    endfunction
endpackage

// File: rtl/evlog_arb.sv
module evlog_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] ack,
    output logic         any
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_pri
        assign ack[i]    = en & req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end
    assign any = en & seen[N];

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack)); // R2
    AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req[0]) |-> ack[0]); // R2
endmodule

// File: rtl/evlog_ring.sv
module evlog_ring #(
    parameter int AW    = 48,
    parameter int IDX_W = 8,
    parameter int SZ_W  = $clog2(IDX_W + 1),
    parameter int SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    base,
    input  logic [SZ_W-1:0]  size,
    input  logic [IDX_W-1:0] head,
    input  logic             advance,
    output logic [IDX_W-1:0] tail,
    output logic             full,
    output logic [AW-1:0]    wr_addr
);
    localparam int SPAN_W = IDX_W + 1;

    logic [SZ_W-1:0]   sz_eff;
    logic [SPAN_W-1:0] span;
    logic [IDX_W-1:0]  mask;
    logic [IDX_W-1:0]  tail_nxt;

    assign sz_eff   = (int'(size) > IDX_W) ? SZ_W'(IDX_W) : size;
    assign span     = SPAN_W'(1) << sz_eff;
    assign mask     = IDX_W'(span - SPAN_W'(1));
    assign tail_nxt = (tail + 1'b1) & mask;
    assign full     = (tail_nxt == (head & mask));
    assign wr_addr  = base + (AW'(tail) << SHIFT);

    always_ff @(posedge clk) begin
        if (!rst_n)       tail <= '0;
        else if (advance) tail <= tail_nxt;
    end

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (tail == (($past(tail) + 1'b1) & $past(mask)))); // R7
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tail)); // R7
endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl
    import evlog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic log_en,
    input  logic any_acc,
    input  logic full,
    input  logic wr_ready,
    input  logic ovf_clr,
    input  logic irq_clr,
    output logic arb_en,
    output logic load,
    output logic wr_valid,
    output logic advance,
    output logic ovf,
    output logic irq
);
    wr_state_t st, st_nxt;
    logic drop_full;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (any_acc && log_en && !full) st_nxt = ST_WRITE;
            ST_WRITE: if (wr_ready)                   st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        arb_en    = (st == ST_IDLE);
        load      = (st == ST_IDLE) && any_acc && log_en && !full;
        drop_full = (st == ST_IDLE) && any_acc && log_en && full;
        wr_valid  = (st == ST_WRITE);
        advance   = (st == ST_WRITE) && wr_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
            irq <= 1'b0;
        end else begin
            if (drop_full)    ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
            if (advance)      irq <= 1'b1;
            else if (irq_clr) irq <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && any_acc && full) |=> !wr_valid); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R4
    AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> irq); // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_en && any_acc && !log_en && !ovf_clr) |=> (!wr_valid && ovf == $past(ovf))); // R6
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> wr_valid); // R10
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid); // R8
endmodule

// File: rtl/evlog_writer.sv
module evlog_writer
    import evlog_pkg::*;
#(
    parameter int AW    = 48,
    parameter int IDX_W = 8,
    parameter int SZ_W  = $clog2(IDX_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 log_en,
    input  logic [AW-1:0]        log_base,
    input  logic [SZ_W-1:0]      log_size,
    input  logic [IDX_W-1:0]     log_head,
    input  logic                 ovf_clr,
    input  logic                 irq_clr,
    input  logic [NSRC-1:0]      src_req,
    input  logic [NSRC*16-1:0]   src_dev,
    input  logic [NSRC*64-1:0]   src_addr,
    input  logic [NSRC*2-1:0]    src_rw,
    output logic [NSRC-1:0]      src_ack,
    output logic                 mem_wr_valid,
    input  logic                 mem_wr_ready,
    output logic [AW-1:0]        mem_wr_addr,
    output logic [ENTRY_W-1:0]   mem_wr_data,
    output logic [IDX_W-1:0]     log_tail,
    output logic                 ovf_flag,
    output logic                 irq_flag
);
    logic   arb_en, any_acc, load, advance, full;
    logic [15:0] sel_dev;
    logic [63:0] sel_addr;
    logic [1:0]  sel_rw;
    logic [3:0]  sel_code;
    entry_t entry_q;

    evlog_arb #(.N(NSRC)) u_arb (
        .clk(clk), .rst_n(rst_n), .en(arb_en),
        .req(src_req), .ack(src_ack), .any(any_acc)
    );

    evlog_ring #(.AW(AW), .IDX_W(IDX_W), .SZ_W(SZ_W), .SHIFT(ENTRY_SHIFT)) u_ring (
        .clk(clk), .rst_n(rst_n), .base(log_base), .size(log_size),
        .head(log_head), .advance(advance), .tail(log_tail),
        .full(full), .wr_addr(mem_wr_addr)
    );

    evlog_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .log_en(log_en), .any_acc(any_acc),
        .full(full), .wr_ready(mem_wr_ready), .ovf_clr(ovf_clr),
        .irq_clr(irq_clr), .arb_en(arb_en), .load(load),
        .wr_valid(mem_wr_valid), .advance(advance),
        .ovf(ovf_flag), .irq(irq_flag)
    );

    // payload of the granted source
    always_comb begin
        sel_dev  = '0;
        sel_addr = '0;
        sel_rw   = '0;
        sel_code = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_ack[i]) begin
                sel_dev  = src_dev[i*16 +: 16];
                sel_addr = src_addr[i*64 +: 64];
                sel_rw   = src_rw[i*2 +: 2];
                sel_code = src_code(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
        end else if (load) begin
            entry_q.addr <= sel_addr;
            entry_q.code <= sel_code;
            entry_q.rsvd <= '0;
            entry_q.rw   <= sel_rw;
            entry_q.dev  <= sel_dev;
        end
    end

    assign mem_wr_data = entry_q;

    AST_WR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> ($stable(mem_wr_data) && $stable(mem_wr_addr))); // R8
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> (src_ack == '0)); // R9
endmodule

// File: tb/sim_evlog_writer.sv
module sim_evlog_writer;
    localparam int AW = 48;
    localparam int IW = 8;
    localparam int SW = 4;
    localparam int NS = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic log_en = 1'b0;
    logic [AW-1:0] log_base = 48'h0000_1000_0000;
    logic [SW-1:0] log_size = 4'd2;
    logic [IW-1:0] log_head = '0;
    logic ovf_clr = 1'b0, irq_clr = 1'b0;
    logic [NS-1:0]    src_req = '0;
    logic [NS*16-1:0] src_dev = '0;
    logic [NS*64-1:0] src_addr = '0;
    logic [NS*2-1:0]  src_rw = '0;
    logic [NS-1:0]    src_ack;
    logic mem_wr_valid;
    logic mem_wr_ready = 1'b0;
    logic [AW-1:0]  mem_wr_addr;
    logic [127:0]   mem_wr_data;
    logic [IW-1:0]  log_tail;
    logic ovf_flag, irq_flag;

    int nchk = 0, nfail = 0;
    logic [IW-1:0] mtail = '0, mhead = '0;
    logic ovf_m = 1'b0, irq_m = 1'b0;
    logic pending = 1'b0;
    logic hold_lo = 1'b0;
    logic [127:0] exp_e = '0;
    bit done = 0;

    evlog_writer #(.AW(AW), .IDX_W(IW), .SZ_W(SW)) u0 (.*);

    always #2 clk = ~clk;  // 250 MHz

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [3:0] code_of(input int s);
        case (s)
            0: return 4'h6;
            1: return 4'h3;
            2: return 4'h4;
            3: return 4'h1;
            default: return 4'h2;
        endcase
    endfunction

    function automatic logic [127:0] mk_entry(input int s, input logic [15:0] d,
                                              input logic [63:0] a, input logic [1:0] rw);
        return {a, code_of(s), 42'b0, rw, d};
    endfunction

    function automatic logic [IW-1:0] mask_of();
        return IW'((9'd1 << log_size) - 9'd1);
    endfunction

    // memory side: ready chosen at falling edge, record checked before handshake edge
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_wr_ready = 1'b0;
        end else begin
            mem_wr_ready = hold_lo ? 1'b0 : (($urandom % 4) != 0);
            if (mem_wr_valid && mem_wr_ready) begin
                if (!pending) chk("R3/R6 unexpected write", 128'd1, 128'd0);
                chk("R1 R2 record", mem_wr_data, exp_e);
                chk("R7 address", 128'(mem_wr_addr), 128'(log_base + (AW'(mtail) << 4)));
                mtail = (mtail + 1'b1) & mask_of();
                pending = 1'b0;
                irq_m = 1'b1;
            end
        end
    end

    // wait for grant of source s, update model, check R10 timing
    task automatic take(input int s);
        logic store;
        #1;
        while (!src_ack[s]) begin
            @(negedge clk);
            #1;
        end
        chk("R2 single grant", 128'(src_ack), 128'(NS'(1) << s));
        store = 1'b0;
        if (!log_en) begin
            store = 1'b0;
        end else if (((mtail + 1'b1) & mask_of()) == (mhead & mask_of())) begin
            ovf_m = 1'b1;
        end else begin
            store = 1'b1;
            pending = 1'b1;
            exp_e = mk_entry(s, src_dev[s*16 +: 16], src_addr[s*64 +: 64], src_rw[s*2 +: 2]);
        end
        @(posedge clk);
        #1;
        src_req[s] = 1'b0;
        @(negedge clk);
        chk("R10 valid after accept", 128'(mem_wr_valid), 128'(store));
    endtask

    task automatic load_src(input int s, input logic [15:0] d, input logic [63:0] a, input logic [1:0] rw);
        src_dev[s*16 +: 16] = d;
        src_addr[s*64 +: 64] = a;
        src_rw[s*2 +: 2] = rw;
        src_req[s] = 1'b1;
    endtask

    task automatic send(input int s, input logic [15:0] d, input logic [63:0] a, input logic [1:0] rw);
        @(negedge clk);
        load_src(s, d, a, rw);
        take(s);
    endtask

    task automatic settle();
        int n = 0;
        while (pending && n < 1000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        chk({tag, " R3 R4 overflow flag"}, 128'(ovf_flag), 128'(ovf_m));
        chk({tag, " R5 interrupt flag"}, 128'(irq_flag), 128'(irq_m));
        chk({tag, " R7 tail index"}, 128'(log_tail), 128'(mtail));
    endtask

    task automatic consume(input int k);
        int occ = int'((mtail - mhead) & mask_of());
        if (k > occ) k = occ;
        @(negedge clk);
        mhead = (mhead + IW'(k)) & mask_of();
        log_head = mhead;
    endtask

    task automatic pulse_ovf_clr();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        ovf_m = 1'b0;
    endtask

    task automatic pulse_irq_clr();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        irq_m = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // reset state
        chk("reset R7 tail", 128'(log_tail), 128'd0);
        chk("reset R4 ovf", 128'(ovf_flag), 128'd0);
        chk("reset R5 irq", 128'(irq_flag), 128'd0);
        chk("reset R8 valid", 128'(mem_wr_valid), 128'd0);
        rst_n = 1'b1;
        log_en = 1'b1;
        @(negedge clk);

        // single page fault, read flag
        send(4, 16'hBEEF, 64'h0123_4567_89AB_C000, 2'b01);
        settle();
        check_state("first record R1");
        pulse_irq_clr();
        check_state("irq clear R5");

        // fill to capacity 3, then one more is dropped
        send(3, 16'h0011, 64'h0000_0000_0000_2000, 2'b10);
        settle();
        send(0, 16'h0022, 64'h0000_0000_0000_3000, 2'b11);
        settle();
        check_state("ring full R7");
        send(2, 16'h0033, 64'h0000_0000_0000_4000, 2'b00);
        settle();
        check_state("drop when full R3");
        repeat (5) @(negedge clk);
        check_state("sticky overflow R4");
        pulse_ovf_clr();
        check_state("overflow clear R4");

        // wrap the tail
        consume(2);
        send(1, 16'h0044, 64'h0000_0000_0000_5000, 2'b01);
        settle();
        send(4, 16'h0055, 64'h0000_0000_0000_6000, 2'b10);
        settle();
        check_state("wrap R7");

        // disabled while full: no write, no overflow
        log_en = 1'b0;
        send(4, 16'h0066, 64'h0000_0000_0000_7000, 2'b01);
        settle();
        check_state("disabled R6");
        log_en = 1'b1;

        // priority and holding
        consume(3);
        hold_lo = 1'b1;
        @(negedge clk);
        load_src(4, 16'h0077, 64'h0000_0000_0000_8000, 2'b10);
        load_src(1, 16'h0088, 64'h0000_0000_0000_9000, 2'b01);
        #1;
        chk("R2 priority grant", 128'(src_ack), 128'(5'b00010));
        take(1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #1;
            chk("R9 no grant while writing", 128'(src_ack), 128'd0);
            chk("R8 valid held", 128'(mem_wr_valid), 128'd1);
        end
        hold_lo = 1'b0;
        @(negedge clk);
        take(4);
        settle();
        check_state("priority R2");

        // constrained random
        for (int it = 0; it < 300; it++) begin
            int s;
            if (it == 150) begin
                consume(8);
                @(negedge clk);
                log_size = 4'd3;
            end
            s = int'($urandom % NS);
            log_en = (($urandom % 10) != 0);
            if (($urandom % 3) == 0) consume(int'($urandom % 4));
            if (($urandom % 8) == 0) pulse_ovf_clr();
            if (($urandom % 5) == 0) pulse_irq_clr();
            send(s, 16'($urandom), {$urandom, $urandom}, 2'($urandom));
            settle();
            check_state("random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule